// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Frequency Synthesizer

This block generates a square wave at a programmable frequency by direct digital synthesis. A 24-bit phase register advances by an active tuning word on every enabled sampling clock and wraps modulo 2^24. The primary square wave is the top bit of that phase. A second square wave at the same frequency is taken from the top bit of the phase plus a programmable offset, which gives a phase-shifted copy.

The host writes tuning words into a holding register. In software-load mode the active word follows the holding register, so a write takes effect from the next clock. In hardware-load mode the active word changes only when an external load strobe rises. That strobe is synchronized into the sampling clock domain before its edge is detected. A ready flag drops when a word is written and rises again once the word has been transferred, which tells the host when the next word may be written.

The tuning word is output frequency divided by sampling frequency, times 2^24. When 2^24 is not an exact multiple of the word, successive output periods differ by one sampling clock. This is inherent to the method and is left uncorrected.

Top module: `psq_synth_top`

## Requirements
- R1: A synchronous active-high reset clears the phase, the holding, active and offset registers, and the synchronizer, and sets `rdy` to 1. Right after reset `phase_o`, `wave_o` and `wave_shift_o` are 0.
- R2: On every clock edge with `en` high, `phase_o` increases by the active tuning word modulo 2^24. `wave_o` equals bit 23 of `phase_o`.
- R3: With `hw_mode` = 0, the active word is loaded from `wr_data` on the edge at which `wr_en` is sampled, and otherwise from the holding register. A pending word therefore takes effect one edge after the mode changes to software. `rdy` stays 1 in this mode.
- R4: With `hw_mode` = 1, a write does not change the active word. The holding register is copied into the active word on the third clock edge after `load_clk` goes high: two synchronizer flops, then the edge detector. A `load_clk` held high transfers only once.
- R5: In hardware-load mode, a write clears `rdy` at the write edge, and a transfer sets it. If a write and a transfer fall on the same edge, the transfer takes the previous holding value and `rdy` stays 0.
- R6: `wave_shift_o` equals bit 23 of (`phase_o` + offset) modulo 2^24. The offset is written through `ofs_wr_en`/`ofs_data`.
- R7: With `en` low, `phase_o`, `wave_o` and `wave_shift_o` hold their values.
- R8: The period of `wave_o` is exactly 2^24/word clocks when that ratio is an integer. Otherwise the period takes two adjacent integer values, differing by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accumulate enable |
| hw_mode | input | 1 | 0: software load, 1: load on strobe |
| wr_en | input | 1 | Write holding register |
| wr_data | input | 24 | Tuning word to write |
| ofs_wr_en | input | 1 | Write phase offset |
| ofs_data | input | 24 | Phase offset value |
| load_clk | input | 1 | Asynchronous load strobe |
| rdy | output | 1 | Holding register free for a new word |
| phase_o | output | 24 | Current phase |
| wave_o | output | 1 | Primary square wave |
| wave_shift_o | output | 1 | Phase-shifted square wave |

## Verification
The assertions assume that `load_clk` reaches the design only through its synchronizer. They also assume that `hw_mode` and the write strobes are steady inputs in the sampling domain, so that one sampled value decides each edge. The bench changes every input just after a falling clock edge and moves `load_clk` only in steps several clocks long, so each strobe edge is seen as a single clean rise. Tuning words are chosen so that periods stay short and divide evenly or unevenly, as each check needs.

// File: rtl/psq_pkg.sv
package psq_pkg;

    localparam int PHASE_W     = 24;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic {
        LOAD_SW = 1'b0,
        LOAD_HW = 1'b1
    } load_mode_e;

    function automatic logic top_bit(input logic [PHASE_W-1:0] v);
        return v[PHASE_W-1];
    endfunction

endpackage

// File: rtl/psq_strobe_sync.sv
module psq_strobe_sync #(
    parameter int DEPTH = psq_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic strobe_rise
);
    localparam int CHAIN = DEPTH + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN-2:0], strobe_async};
    end

    // rise seen after DEPTH flops, compared with one extra stage
    assign strobe_rise = chain_q[DEPTH-1] & ~chain_q[DEPTH];
endmodule

// File: rtl/psq_tune_ctrl.sv
module psq_tune_ctrl
    import psq_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  load_mode_e   mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ofs_wr_en,
    input  logic [W-1:0] ofs_data,
    input  logic         load_rise,
    output logic [W-1:0] tune,
    output logic [W-1:0] offset,
    output logic         rdy
);
    logic [W-1:0] hold_q;
    logic [W-1:0] tune_q;
    logic [W-1:0] ofs_q;
    logic         rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            tune_q <= '0;
            ofs_q  <= '0;
            rdy_q  <= 1'b1;
        end else begin
            if (wr_en)     hold_q <= wr_data;
            if (ofs_wr_en) ofs_q  <= ofs_data;
            if (mode == LOAD_SW) begin
                tune_q <= wr_en ? wr_data : hold_q;
                rdy_q  <= 1'b1;
            end else begin
                if (load_rise) tune_q <= hold_q;
                if (wr_en)          rdy_q <= 1'b0;
                else if (load_rise) rdy_q <= 1'b1;
            end
        end
    end

    assign tune   = tune_q;
    assign offset = ofs_q;
    assign rdy    = rdy_q;
endmodule

// File: rtl/psq_phase_core.sv
module psq_phase_core
    import psq_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] tune,
    input  logic [W-1:0] offset,
    output logic [W-1:0] phase,
    output logic         wave,
    output logic         wave_shift
);
    logic [W-1:0] acc_q;
    logic [W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= acc_q + tune;
    end

    assign shifted    = acc_q + offset;
    assign phase      = acc_q;
    assign wave       = acc_q[W-1];
    assign wave_shift = shifted[W-1];
endmodule

// File: rtl/psq_synth_top.sv
module psq_synth_top
    import psq_pkg::*;
#(
    parameter int W          = PHASE_W,
    parameter int SYNC_DEPTH = psq_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         hw_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ofs_wr_en,
    input  logic [W-1:0] ofs_data,
    input  logic         load_clk,
    output logic         rdy,
    output logic [W-1:0] phase_o,
    output logic         wave_o,
    output logic         wave_shift_o
);
    load_mode_e   mode;
    logic         load_rise;
    logic [W-1:0] tune_w;
    logic [W-1:0] ofs_w;

    assign mode = hw_mode ? LOAD_HW : LOAD_SW;

    psq_strobe_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .strobe_async(load_clk), .strobe_rise(load_rise)
    );

    psq_tune_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .mode(mode),
        .wr_en(wr_en), .wr_data(wr_data),
        .ofs_wr_en(ofs_wr_en), .ofs_data(ofs_data),
        .load_rise(load_rise),
        .tune(tune_w), .offset(ofs_w), .rdy(rdy)
    );

    psq_phase_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .en(en),
        .tune(tune_w), .offset(ofs_w),
        .phase(phase_o), .wave(wave_o), .wave_shift(wave_shift_o)
    );
endmodule

// File: rtl/psq_synth_chk.sv
module psq_synth_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         hw_mode,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         load_rise,
    input logic [W-1:0] tune_w,
    input logic [W-1:0] phase_o,
    input logic         wave_o,
    input logic         wave_shift_o,
    input logic         rdy
);
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        en |=> phase_o == $past(phase_o) + $past(tune_w));

    a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase_o) && $stable(wave_o) && $stable(wave_shift_o)));

    a_r3_sw_write: assert property (@(posedge clk) disable iff (rst)
        (!hw_mode && wr_en) |=> tune_w == $past(wr_data));

    a_r3_sw_ready: assert property (@(posedge clk) disable iff (rst)
        !hw_mode |=> rdy);

    a_r4_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && !load_rise) |=> $stable(tune_w));

    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && wr_en) |=> !rdy);

    a_r5_transfer_sets: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && load_rise && !wr_en) |=> rdy);
endmodule

bind psq_synth_top psq_synth_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .hw_mode(hw_mode),
    .wr_en(wr_en), .wr_data(wr_data), .load_rise(load_rise),
    .tune_w(tune_w), .phase_o(phase_o), .wave_o(wave_o),
    .wave_shift_o(wave_shift_o), .rdy(rdy)
);

// File: tb/sim_psq_synth_top.sv
`timescale 1ns/1ps
module sim_psq_synth_top;
    localparam int W = 24;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         hw_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         ofs_wr_en = 1'b0;
    logic [W-1:0] ofs_data = '0;
    logic         load_clk = 1'b0;
    logic         rdy;
    logic [W-1:0] phase_o;
    logic         wave_o;
    logic         wave_shift_o;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] prev_ph = '0;
    logic [W-1:0] delta = '0;

    always #2.5 clk = ~clk;

    psq_synth_top u0 (
        .clk(clk), .rst(rst), .en(en), .hw_mode(hw_mode),
        .wr_en(wr_en), .wr_data(wr_data),
        .ofs_wr_en(ofs_wr_en), .ofs_data(ofs_data),
        .load_clk(load_clk), .rdy(rdy), .phase_o(phase_o),
        .wave_o(wave_o), .wave_shift_o(wave_shift_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        delta   = phase_o - prev_ph;
        prev_ph = phase_o;
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 0; ofs_wr_en = 0; load_clk = 0; en = 0; hw_mode = 0;
        step(); step();
        rst = 1'b0; en = 1'b1;
        prev_ph = phase_o;
    endtask

    task automatic write_word(input logic [W-1:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    // R8: measure period extremes of wave_o
    task automatic measure(input logic [W-1:0] t, output int pmin, output int pmax);
        int last = -1;
        int cyc = 0;
        logic pw;
        pmin = 1 << 30; pmax = 0;
        do_reset();
        write_word(t);
        pw = wave_o;
        for (int i = 0; i < 400; i++) begin
            step(); cyc++;
            if (wave_o && !pw) begin
                if (last >= 0) begin
                    if (cyc - last < pmin) pmin = cyc - last;
                    if (cyc - last > pmax) pmax = cyc - last;
                end
                last = cyc;
            end
            pw = wave_o;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] tunes [6];
        logic [W-1:0] ofss [4];
        logic [W-1:0] sh;
        logic [W-1:0] frz;
        logic fw, fs;
        bit ok;
        int pmin, pmax;
        tunes = '{24'h000001, 24'h080000, 24'h200000, 24'h555555, 24'hA3D70A, 24'hFFFFFF};
        ofss  = '{24'h000000, 24'h400000, 24'h800000, 24'h123456};

        // R1 reset state
        rst = 1'b1; step(); step();
        chk(phase_o == 0, "R1 phase", phase_o, 0);
        chk(rdy == 1'b1, "R1 rdy", rdy, 1);
        chk(wave_o == 0 && wave_shift_o == 0, "R1 waves", {wave_o, wave_shift_o}, 0);
        rst = 1'b0; en = 1'b1; prev_ph = phase_o;
        step();
        chk(phase_o == 0, "R1 zero word", phase_o, 0);

        // R2 R6 R3 sweep over words and offsets, software mode
        foreach (tunes[i]) foreach (ofss[j]) begin
            do_reset();
            ofs_wr_en = 1'b1; ofs_data = ofss[j];
            wr_en = 1'b1; wr_data = tunes[i];
            step();
            ofs_wr_en = 1'b0; wr_en = 1'b0;
            chk(delta == 0, "R3 write edge uses old word", delta, 0);
            chk(rdy == 1'b1, "R3 rdy held", rdy, 1);
            ok = 1'b1;
            for (int k = 0; k < 48; k++) begin
                step();
                sh = (phase_o + ofss[j]) & MASK;
                if (delta != tunes[i] || wave_o != phase_o[W-1] || wave_shift_o != sh[W-1]) ok = 0;
            end
            chk(ok, "R2 R6 sweep", delta, tunes[i]);
        end

        // R7 enable low
        do_reset();
        write_word(24'h0C0000);
        step(); step(); step();
        en = 1'b0;
        step();
        frz = phase_o; fw = wave_o; fs = wave_shift_o;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step();
            if (phase_o != frz || wave_o != fw || wave_shift_o != fs) ok = 0;
        end
        chk(ok, "R7 frozen", phase_o, frz);
        en = 1'b1;
        step(); step();
        chk(delta == 24'h0C0000, "R7 resume", delta, 24'h0C0000);

        // R4 R5 hardware load
        do_reset();
        write_word(24'h010000);
        hw_mode = 1'b1;
        write_word(24'h020000);
        chk(rdy == 1'b0, "R5 write clears rdy", rdy, 0);
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin step(); if (delta != 24'h010000) ok = 0; end
        chk(ok, "R4 write alone no effect", delta, 24'h010000);
        load_clk = 1'b1;
        step(); step();
        chk(rdy == 1'b0, "R4 not before third edge", rdy, 0);
        step();
        chk(rdy == 1'b1, "R5 transfer sets rdy", rdy, 1);
        chk(delta == 24'h010000, "R4 old word on transfer edge", delta, 24'h010000);
        step();
        chk(delta == 24'h020000, "R4 new word active", delta, 24'h020000);
        write_word(24'h030000);
        ok = 1'b1;
        for (int k = 0; k < 6; k++) begin step(); if (delta != 24'h020000 || rdy) ok = 0; end
        chk(ok, "R4 held strobe single transfer", delta, 24'h020000);
        load_clk = 1'b0;
        step(); step(); step();
        load_clk = 1'b1;
        step(); step(); step(); step();
        chk(delta == 24'h030000 && rdy, "R4 second strobe", delta, 24'h030000);

        // R5 write coinciding with transfer
        load_clk = 1'b0;
        step(); step(); step();
        write_word(24'h040000);
        load_clk = 1'b1;
        step(); step();
        wr_en = 1'b1; wr_data = 24'h050000;
        step();
        wr_en = 1'b0;
        chk(rdy == 1'b0, "R5 collision keeps rdy low", rdy, 0);
        step();
        chk(delta == 24'h040000, "R5 collision transfers prior word", delta, 24'h040000);

        // R3 switch to software applies pending word
        hw_mode = 1'b0;
        step();
        chk(rdy == 1'b1, "R3 rdy on switch", rdy, 1);
        step();
        chk(delta == 24'h050000, "R3 pending word applied", delta, 24'h050000);

        // R8 periods
        measure(24'h080000, pmin, pmax);
        chk(pmin == 32 && pmax == 32, "R8 exact period", pmax, 32);
        measure(24'h0A72F0, pmin, pmax);
        chk(pmin == 24 && pmax == 25, "R8 one-clock spread", pmax - pmin, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule